// File: doc/BRIEF.md
# Packed Stereo Serial Audio Receiver

This block deserializes a stereo audio stream that uses 32 bit clocks per frame. Each frame-clock half holds exactly one 16-bit sample, sent MSB first. The MSB is the first bit sampled after a frame-clock change. The LSB is the last bit sampled before the next change. There are no idle bit slots, so the block finds word boundaries from frame-clock transitions alone.

The whole block runs on the rising edge of the incoming bit clock. Each half frame is turned into a parallel word and placed in the left or right holding register. A one-cycle strobe marks the moment a right word completes, which is when the left and right outputs form one coherent stereo pair. A sticky error flag records any half frame whose length is not exactly 16 bits.

Top module: `pkd_audio_rx`

## Requirements
- R1: While `rst_n` is low, `left_word` and `right_word` read 0 and `pair_valid` and `frame_err` read 0.
- R2: `sdata` is sampled on each rising edge of `bclk`. The bit sampled at the first rising edge after a change of `fclk` is bit 15 (MSB) of the new word. The next 15 bits fill bits 14 down to 0.
- R3: A word sampled while `fclk` is 1 goes to `left_word`. A word sampled while `fclk` is 0 goes to `right_word`. Neither output changes during a half frame of the other level.
- R4: A holding register takes its new value on the same rising edge that samples the 16th bit of the half. It keeps that value until the next completed half of the same level.
- R5: `pair_valid` is 1 for exactly one `bclk` cycle, which starts at the edge that stores a right word. It is never raised for a left word.
- R6: Once at least one `fclk` change has been seen since reset, a change that ends a half of any length other than 16 bits sets `frame_err`. The flag stays set until reset.
- R7: Bits received before the first `fclk` change after reset are discarded. They change no output and do not set `frame_err`.
- R8: A half frame shorter than 16 bits stores nothing. The holding register for that level keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fclk | input | 1 | Frame clock: 1 selects left, 0 selects right |
| sdata | input | 1 | Serial sample data, MSB first |
| left_word | output | 16 | Last completed left sample |
| right_word | output | 16 | Last completed right sample |
| pair_valid | output | 1 | One-cycle strobe when a stereo pair is complete |
| frame_err | output | 1 | Sticky flag for a half frame of the wrong length |

## Verification
If the bit counter is off by one, words come out shifted by one place. This shows in the output sampled one bit time after the 16th bit of the first synchronized half. If the channel selection is wrong, the sample appears on the other output in that same cycle. If the edge detector or the counter restart is faulty, `frame_err` is set falsely, or fails to set, on the first frame-clock change that ends a bad half. A wrong strobe shows as a missing, doubled or left-side pulse at the end of the first full frame.

// File: rtl/pkd_audio_rx.sv
module pkd_audio_rx #(
  parameter int WORD_BITS = 16
) (
  input  logic                 bclk,
  input  logic                 rst_n,
  input  logic                 fclk,
  input  logic                 sdata,
  output logic [WORD_BITS-1:0] left_word,
  output logic [WORD_BITS-1:0] right_word,
  output logic                 pair_valid,
  output logic                 frame_err
);
  localparam int CW = $clog2(WORD_BITS) + 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);
  localparam logic [CW-1:0] CMAX = '1;

  logic                 fclk_q, primed, synced;
  logic [CW-1:0]        cnt;
  logic [WORD_BITS-1:0] sr;

  wire                 edge_now = primed && (fclk != fclk_q);
  wire [CW-1:0]        pos      = edge_now ? '0 : ((cnt == CMAX) ? CMAX : cnt + 1'b1);
  wire [WORD_BITS-1:0] word_in  = {sr[WORD_BITS-2:0], sdata};
  wire                 done     = (synced || edge_now) && (pos == LAST);
  wire                 bad_len  = edge_now && synced && (cnt != LAST);

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q     <= 1'b0;
      primed     <= 1'b0;
      synced     <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      left_word  <= '0;
      right_word <= '0;
      pair_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      fclk_q     <= fclk;
      primed     <= 1'b1;
      synced     <= synced || edge_now;
      cnt        <= pos;
      sr         <= word_in;
      pair_valid <= done && !fclk;
      if (done && fclk)  left_word  <= word_in;
      if (done && !fclk) right_word <= word_in;
      if (bad_len)       frame_err  <= 1'b1;
    end
  end
endmodule

module pkd_audio_rx_chk #(
  parameter int W = 16
) (
  input logic         bclk,
  input logic         rst_n,
  input logic         fclk,
  input logic         pair_valid,
  input logic         frame_err,
  input logic [W-1:0] left_word,
  input logic [W-1:0] right_word
);
  AST_PAIR_ONE_CYCLE:  assert property (@(posedge bclk) disable iff (!rst_n) pair_valid |=> !pair_valid); // R5
  AST_PAIR_AFTER_RIGHT: assert property (@(posedge bclk) disable iff (!rst_n) pair_valid |-> !$past(fclk)); // R5
  AST_LEFT_FROM_HIGH:  assert property (@(posedge bclk) disable iff (!rst_n) !$stable(left_word) |-> $past(fclk)); // R3
  AST_RIGHT_FROM_LOW:  assert property (@(posedge bclk) disable iff (!rst_n) !$stable(right_word) |-> !$past(fclk)); // R3
  AST_RIGHT_WITH_PAIR: assert property (@(posedge bclk) disable iff (!rst_n) !$stable(right_word) |-> pair_valid); // R4
  AST_ERR_STICKY:      assert property (@(posedge bclk) disable iff (!rst_n) frame_err |=> frame_err); // R6
endmodule

bind pkd_audio_rx pkd_audio_rx_chk #(.W(WORD_BITS)) u_chk (
  .bclk(bclk), .rst_n(rst_n), .fclk(fclk), .pair_valid(pair_valid),
  .frame_err(frame_err), .left_word(left_word), .right_word(right_word)
);

// File: tb/pkd_audio_rx_test.sv
`timescale 1ns/1ps
module pkd_audio_rx_test;
  logic bclk = 1'b0, rst_n = 1'b0, fclk = 1'b0, sdata = 1'b0;
  logic [15:0] left_word, right_word;
  logic pair_valid, frame_err;
  int n_run = 0, n_fail = 0;
  bit pend = 0, pend_l = 0, was_pend = 0;
  logic [15:0] exp_l = '0, exp_r = '0;

  pkd_audio_rx uut (.bclk(bclk), .rst_n(rst_n), .fclk(fclk), .sdata(sdata),
    .left_word(left_word), .right_word(right_word), .pair_valid(pair_valid), .frame_err(frame_err));

  always #10 bclk = ~bclk;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send_half(input logic lvl, input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge bclk);
      if (i == 0) begin
        was_pend = pend;
        if (pend) begin
          check(pair_valid === 1'b1, "R5 strobe after right", {15'd0, pair_valid}, 16'd1);
          check(left_word === exp_l, "R3 left word", left_word, exp_l);
          check(right_word === exp_r, "R2 right word", right_word, exp_r);
          pend = 0;
        end else begin
          check(pair_valid === 1'b0, "R5 no strobe", {15'd0, pair_valid}, 16'd0);
        end
        if (pend_l) begin
          check(left_word === exp_l, "R4 left stored at 16th bit", left_word, exp_l);
          pend_l = 0;
        end
      end else if (i == 1 && was_pend) begin
        check(pair_valid === 1'b0, "R5 strobe one cycle", {15'd0, pair_valid}, 16'd0);
      end
      fclk = lvl;
      sdata = (i < 16) ? w[15 - i] : 1'b0;
    end
  endtask

  task automatic frame(input logic [15:0] l, input logic [15:0] r);
    send_half(1'b1, l, 16);
    exp_l = l; pend_l = 1;
    send_half(1'b0, r, 16);
    exp_r = r; pend = 1;
  endtask

  task automatic do_reset();
    @(negedge bclk);
    rst_n = 0; fclk = 0; sdata = 0; pend = 0; pend_l = 0;
    exp_l = '0; exp_r = '0;
    repeat (3) @(negedge bclk);
    check(left_word === 16'd0 && right_word === 16'd0, "R1 words in reset", left_word | right_word, 16'd0);
    check(pair_valid === 1'b0 && frame_err === 1'b0, "R1 flags in reset", {14'd0, pair_valid, frame_err}, 16'd0);
    rst_n = 1;
  endtask

  initial begin
    #(20ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // Test A: sync, sweep
    do_reset();
    send_half(1'b0, 16'hFFFF, 5);
    @(negedge bclk);
    check(left_word === 16'd0 && right_word === 16'd0, "R7 no capture before sync", left_word | right_word, 16'd0);
    check(frame_err === 1'b0, "R7 no error before sync", {15'd0, frame_err}, 16'd0);
    fclk = 1'b0; sdata = 1'b0;
    for (int k = 0; k < 16; k++) frame(16'(1 << k), 16'(16'h8000 >> k));
    for (int k = 0; k < 32; k++) frame(16'(k * 40503 + 7), ~16'(k * 12289 + 3));
    frame(16'h0000, 16'hFFFF);
    frame(16'hFFFF, 16'h0000);
    send_half(1'b1, 16'h1234, 16);
    @(negedge bclk);
    check(frame_err === 1'b0, "R6 no error on good frames", {15'd0, frame_err}, 16'd0);

    // Test B: short left half
    do_reset();
    send_half(1'b0, 16'h0, 3);
    frame(16'hA5C3, 16'h3C5A);
    send_half(1'b1, 16'hFFFF, 10);
    send_half(1'b0, 16'h7E81, 16);
    exp_l = 16'hA5C3; exp_r = 16'h7E81; pend = 1;
    send_half(1'b1, 16'h0F0F, 16);
    check(left_word === 16'hA5C3, "R8 short half keeps left", left_word, 16'hA5C3);
    check(frame_err === 1'b1, "R6 short half error", {15'd0, frame_err}, 16'd1);
    exp_l = 16'h0F0F; pend_l = 1;
    send_half(1'b0, 16'h1111, 16);
    exp_r = 16'h1111; pend = 1;
    send_half(1'b1, 16'h2222, 16);
    check(frame_err === 1'b1, "R6 error sticky", {15'd0, frame_err}, 16'd1);

    // Test C: long right half
    do_reset();
    send_half(1'b0, 16'h0, 2);
    frame(16'h4321, 16'h8765);
    send_half(1'b1, 16'h1357, 16);
    check(frame_err === 1'b0, "R6 no error yet", {15'd0, frame_err}, 16'd0);
    send_half(1'b0, 16'h9BDF, 20);
    check(right_word === 16'h9BDF, "R4 first 16 bits stored", right_word, 16'h9BDF);
    send_half(1'b1, 16'h0, 16);
    @(negedge bclk);
    check(frame_err === 1'b1, "R6 long half error", {15'd0, frame_err}, 16'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule